// File: doc/BRIEF.md
# Power-Up and Stop-Exit Startup Sequencer

This block brings a device out of power-on reset or out of stop mode in a fixed order. It enables the fast oscillator clock, releases the analog front end, and releases the processor last. It counts time in two domains. Supply settling is measured in ticks of the slow (32 kHz) reference. Oscillator warm-up is measured in ticks of the fast (5 MHz) oscillator. Both tick inputs are single-cycle strobes in the block's own clock domain.

After power-on the block waits four slow ticks for the supply to settle. It then ungates the fast clock, releases the front end and counts eight fast ticks. It holds the processor back until at least one slow tick has passed since the front end was released. On a stop request the fast clock is gated and the processor is held, while the front end stays released. On a stop-exit request the fast clock is ungated at once and the warm-up count starts from zero. The block then waits for the flash-ready input, counts eight fast ticks and releases the processor. When the sequence is complete its counters are held cleared and ignore all ticks.

Top module: `startup_seq_timer`

## Requirements
- R1: A high `rst` at any clock edge drives all four outputs low. After `rst` falls, the sequence restarts from the settling phase with no ticks counted.
- R2: After reset, all outputs stay low until the fourth `slow_tick`. The cycle after that tick is registered, `fast_clk_en` and `afe_release` rise together.
- R3: During power-up, `cpu_release` stays low until eight `fast_tick` strobes have been counted after the front-end release.
- R4: `cpu_release` never rises unless a `slow_tick` has been seen after `afe_release` rose. If eight fast ticks complete first, the processor release waits for the next slow tick. If a slow tick already came, the processor is released as soon as the eighth fast tick is counted.
- R5: `seq_done` rises together with `cpu_release` and stays high while running. Slow and fast ticks in this state change no output.
- R6: While running, a `stop_enter` strobe drops `fast_clk_en`, `cpu_release` and `seq_done`, and keeps `afe_release` high.
- R7: In stop, a `stop_exit` strobe raises `fast_clk_en` in the next cycle. Fast ticks are ignored until `flash_ready` is high. After that, eight fast ticks release the processor, with no further slow-tick wait.
- R8: `stop_exit` has no effect outside the stop state, and `stop_enter` has no effect outside the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| slow_tick | input | 1 | One-cycle strobe per slow reference period |
| fast_tick | input | 1 | One-cycle strobe per fast oscillator period |
| stop_enter | input | 1 | Request to enter stop mode |
| stop_exit | input | 1 | Wake-up event ending stop mode |
| flash_ready | input | 1 | Flash memory powered up |
| fast_clk_en | output | 1 | Fast clock gate enable |
| afe_release | output | 1 | Analog front end out of reset |
| cpu_release | output | 1 | Processor out of reset |
| seq_done | output | 1 | Startup sequence complete |

## Verification
On every cycle the assertions check the ordering of the releases. The processor is never released ahead of the front end or with the fast clock gated, `seq_done` never appears without the processor release, and reset clears all outputs. A stop request from the running state must drop the processor and the clock but keep the front end released. The exact counts of four slow ticks and eight fast ticks can only be shown by the bench scenarios. So can the two orderings of the slow-tick gap, flash-ready gating on stop exit, ignored requests and ticks, and a reset in the middle of warm-up.

// File: rtl/startup_pkg.sv
package startup_pkg;

    localparam int unsigned SETTLE_SLOW_TICKS = 4;
    localparam int unsigned WARM_FAST_TICKS   = 8;

    typedef enum logic [2:0] {
        ST_SETTLE = 3'd0,
        ST_WARM   = 3'd1,
        ST_HOLD   = 3'd2,
        ST_RUN    = 3'd3,
        ST_STOP   = 3'd4,
        ST_FLASH  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic fast_gate;
        logic afe_rel;
        logic cpu_rel;
        logic done;
    } rel_out_t;

    function automatic rel_out_t decode_outputs(seq_state_e s);
        rel_out_t o;
        o = '0;
        case (s)
            ST_WARM, ST_HOLD, ST_FLASH: begin
                o.fast_gate = 1'b1;
                o.afe_rel   = 1'b1;
            end
            ST_RUN: begin
                o.fast_gate = 1'b1;
                o.afe_rel   = 1'b1;
                o.cpu_rel   = 1'b1;
                o.done      = 1'b1;
            end
            ST_STOP: o.afe_rel = 1'b1;
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic reached
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIMIT_W = W'(LIMIT);

    logic [W-1:0] cnt;

    assign reached = (cnt == LIMIT_W);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && !reached) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gap_tracker.sv
module gap_tracker (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic arm,
    input  logic watch,
    input  logic slow_tick,
    output logic gap_ok
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gap_ok <= 1'b0;
        end else if (arm || (watch && slow_tick)) begin
            gap_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/startup_seq_timer.sv
module startup_seq_timer
    import startup_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = SETTLE_SLOW_TICKS,
    parameter int unsigned WARM_TICKS   = WARM_FAST_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_tick,
    input  logic fast_tick,
    input  logic stop_enter,
    input  logic stop_exit,
    input  logic flash_ready,
    output logic fast_clk_en,
    output logic afe_release,
    output logic cpu_release,
    output logic seq_done
);
    seq_state_e state, state_nx;
    logic       settle_hit;
    logic       warm_hit;
    logic       gap_ok;
    rel_out_t   outs;

    tick_counter #(.LIMIT(SETTLE_TICKS)) u_settle_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_SETTLE),
        .tick    (slow_tick),
        .reached (settle_hit)
    );

    tick_counter #(.LIMIT(WARM_TICKS)) u_warm_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (state != ST_WARM),
        .tick    (fast_tick),
        .reached (warm_hit)
    );

    gap_tracker u_gap (
        .clk       (clk),
        .rst       (rst),
        .clear     (state == ST_SETTLE),
        .arm       (state == ST_STOP),
        .watch     ((state == ST_WARM) || (state == ST_HOLD)),
        .slow_tick (slow_tick),
        .gap_ok    (gap_ok)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_SETTLE: if (settle_hit)  state_nx = ST_WARM;
            ST_WARM:   if (warm_hit)    state_nx = gap_ok ? ST_RUN : ST_HOLD;
            ST_HOLD:   if (gap_ok)      state_nx = ST_RUN;
            ST_RUN:    if (stop_enter)  state_nx = ST_STOP;
            ST_STOP:   if (stop_exit)   state_nx = ST_FLASH;
            ST_FLASH:  if (flash_ready) state_nx = ST_WARM;
            default:                    state_nx = ST_SETTLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SETTLE;
        end else begin
            state <= state_nx;
        end
    end

    assign outs        = decode_outputs(state);
    assign fast_clk_en = outs.fast_gate;
    assign afe_release = outs.afe_rel;
    assign cpu_release = outs.cpu_rel;
    assign seq_done    = outs.done;
endmodule

// File: rtl/startup_seq_checker.sv
module startup_seq_checker (
    input logic clk,
    input logic rst,
    input logic stop_enter,
    input logic fast_clk_en,
    input logic afe_release,
    input logic cpu_release,
    input logic seq_done
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!fast_clk_en && !afe_release && !cpu_release && !seq_done));

    assert_afe_with_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(afe_release) |-> fast_clk_en);

    assert_cpu_needs_clock_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_release |-> fast_clk_en);

    assert_afe_before_cpu_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_release) |-> $past(afe_release));

    assert_done_with_cpu_R5: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> cpu_release);

    assert_stop_keeps_afe_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_release && stop_enter) |=> (!cpu_release && !fast_clk_en && afe_release));
endmodule

bind startup_seq_timer startup_seq_checker u_startup_seq_checker (
    .clk         (clk),
    .rst         (rst),
    .stop_enter  (stop_enter),
    .fast_clk_en (fast_clk_en),
    .afe_release (afe_release),
    .cpu_release (cpu_release),
    .seq_done    (seq_done)
);

// File: tb/test_startup_seq_timer.sv
module test_startup_seq_timer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slow_tick = 1'b0;
    logic fast_tick = 1'b0;
    logic stop_enter = 1'b0;
    logic stop_exit = 1'b0;
    logic flash_ready = 1'b0;
    logic fast_clk_en, afe_release, cpu_release, seq_done;

    int compared = 0;
    int mismatched = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    logic [3:0] last_out;
    logic [3:0] exp_q[$];

    // Vector layout {seq_done, cpu_release, afe_release, fast_clk_en}
    localparam logic [3:0] V_OFF  = 4'b0000;
    localparam logic [3:0] V_WARM = 4'b0011;
    localparam logic [3:0] V_RUN  = 4'b1111;
    localparam logic [3:0] V_STOP = 4'b0010;

    always #2 clk = ~clk;

    startup_seq_timer i_startup_seq_timer (
        .clk         (clk),
        .rst         (rst),
        .slow_tick   (slow_tick),
        .fast_tick   (fast_tick),
        .stop_enter  (stop_enter),
        .stop_exit   (stop_exit),
        .flash_ready (flash_ready),
        .fast_clk_en (fast_clk_en),
        .afe_release (afe_release),
        .cpu_release (cpu_release),
        .seq_done    (seq_done)
    );

    function automatic logic [3:0] cur_out();
        return {seq_done, cpu_release, afe_release, fast_clk_en};
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // monitor: every output change pops one expected item
    always @(negedge clk) begin
        if (mon_en && cur_out() !== last_out) begin
            if (exp_q.size() == 0) begin
                compared++;
                mismatched++;
                $display("FAIL unexpected transition actual=%b expected=%b", cur_out(), last_out);
            end else begin
                check("scoreboard transition", cur_out(), exp_q.pop_front());
            end
            last_out = cur_out();
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(ref logic sig, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 sig = 1'b1;
            @(posedge clk); #1 sig = 1'b0;
            idle(1);
        end
    endtask

    task automatic expect_next(logic [3:0] v);
        exp_q.push_back(v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        check("R1 reset state", cur_out(), V_OFF);
        last_out = V_OFF;
        mon_en = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        idle(3);

        // R2: three slow ticks are not enough
        pulse(slow_tick, 3);
        idle(3);
        check("R2 before fourth slow tick", cur_out(), V_OFF);
        expect_next(V_WARM);
        pulse(slow_tick, 1);
        idle(3);
        check("R2 gate and afe after fourth slow tick", cur_out(), V_WARM);

        // R3: seven fast ticks keep cpu held
        pulse(fast_tick, 7);
        idle(3);
        check("R3 cpu held after seven fast ticks", cur_out(), V_WARM);
        pulse(fast_tick, 1);
        idle(3);
        check("R4 cpu waits for slow tick after warm-up", cur_out(), V_WARM);
        expect_next(V_RUN);
        pulse(slow_tick, 1);
        idle(3);
        check("R4 cpu released after slow gap", cur_out(), V_RUN);

        // R5 / R8: ticks and stop_exit in run are ignored
        pulse(slow_tick, 2);
        pulse(fast_tick, 3);
        pulse(stop_exit, 1);
        idle(3);
        check("R5 R8 run unaffected by ticks and stop_exit", cur_out(), V_RUN);

        // R6: stop entry
        expect_next(V_STOP);
        pulse(stop_enter, 1);
        idle(3);
        check("R6 stop keeps afe only", cur_out(), V_STOP);
        pulse(stop_enter, 1);
        pulse(fast_tick, 9);
        pulse(slow_tick, 5);
        idle(3);
        check("R8 stop_enter and ticks ignored in stop", cur_out(), V_STOP);

        // R7: stop exit waits for flash
        expect_next(V_WARM);
        pulse(stop_exit, 1);
        idle(2);
        check("R7 fast clock ungated on stop exit", cur_out(), V_WARM);
        pulse(fast_tick, 9);
        idle(3);
        check("R7 fast ticks ignored before flash ready", cur_out(), V_WARM);
        @(posedge clk); #1 flash_ready = 1'b1;
        idle(3);
        pulse(fast_tick, 7);
        idle(3);
        check("R7 seven fast ticks after flash ready", cur_out(), V_WARM);
        expect_next(V_RUN);
        pulse(fast_tick, 1);
        idle(3);
        check("R7 cpu released after eight fast ticks", cur_out(), V_RUN);
        flash_ready = 1'b0;

        // R1: reset from run
        expect_next(V_OFF);
        rst = 1'b1;
        idle(2);
        check("R1 reset from run", cur_out(), V_OFF);
        rst = 1'b0;
        idle(2);

        // R4: slow tick arrives during warm-up
        expect_next(V_WARM);
        pulse(slow_tick, 4);
        idle(3);
        check("R2 second power-up release", cur_out(), V_WARM);
        pulse(slow_tick, 1);
        pulse(fast_tick, 7);
        idle(3);
        check("R3 cpu held with gap already met", cur_out(), V_WARM);
        expect_next(V_RUN);
        pulse(fast_tick, 1);
        idle(3);
        check("R4 direct release when gap met early", cur_out(), V_RUN);

        // R1: reset in the middle of warm-up restarts the sequence
        expect_next(V_OFF);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(2);
        expect_next(V_WARM);
        pulse(slow_tick, 4);
        pulse(fast_tick, 3);
        expect_next(V_OFF);
        rst = 1'b1;
        idle(2);
        check("R1 reset mid warm-up", cur_out(), V_OFF);
        rst = 1'b0;
        idle(2);
        pulse(slow_tick, 3);
        idle(3);
        check("R1 settle count restarted", cur_out(), V_OFF);
        expect_next(V_WARM);
        pulse(slow_tick, 1);
        pulse(fast_tick, 8);
        idle(3);
        check("R1 warm count restarted", cur_out(), V_WARM);
        expect_next(V_RUN);
        pulse(slow_tick, 1);
        idle(3);
        check("R5 done with cpu release", cur_out(), V_RUN);

        idle(4);
        compared++;
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL R5 pending transitions actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule